// File: doc/BRIEF.md
# Scalar Load/Store Request Formatter

This block sits between the register read stage and the data memory port of a small scalar core. For every byte, halfword or word load or store it takes the instruction word and the two register operands. It turns them into one memory request: a byte address, store data already moved into place, a write mask in bit and byte form, a read mask for the extension of load data, the amount by which the returned word must be shifted right, and the index of the register to write back.

The access width comes from the opcode. The low two bits of a three-bit request index give a size code, and the shift is derived from that code by arithmetic rather than from a table. Bit 2 of the index picks zero extension over sign extension. A store writes no register, so its destination index is forced to zero. The request leaves through one output register stage, marked by a valid strobe.

Top module: `ldst_req_fmt`

## Requirements
- R1: One cycle after `in_valid` is high, `req_addr` equals `base_val` plus the sign-extended `instr[15:0]`, taken modulo 2^32.
- R2: `req_valid` is high exactly in the cycle after each cycle in which `in_valid` is high. After reset all outputs are zero.
- R3: The request index is `instr[28:26]` and its low two bits are the size code (0 byte, 1 half, 2 three bytes, 3 word). `req_shamt` equals (3 − size code) × 8, giving 24, 16, 8 and 0.
- R4: `req_wdata` equals `src_val` shifted left by `req_shamt`, with the bits shifted out lost.
- R5: For a store (`instr[29]` = 1), `req_wmask` equals 0xFFFFFFFF shifted left by `req_shamt`. For a load it is zero.
- R6: Bit i of `req_wbe` is bit 8i+7 of `req_wmask`. That gives 4'b1000, 4'b1100, 4'b1110 and 4'b1111 for size codes 0 to 3 on a store, and 4'b0000 on a load.
- R7: `req_dest` equals `instr[20:16]` for a load and 0 for a store.
- R8: `req_rmask` by request index: 0, 1, 3 and 7 give 0xFFFFFFFF; 2 and 6 give 0; 4 gives 0x000000FF; 5 gives 0x0000FFFF.
- R9: In a cycle after one in which `in_valid` is low, every request output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Base register operand |
| src_val | input | 32 | Store source / second register operand |
| req_valid | output | 1 | Request strobe |
| req_addr | output | 32 | Effective byte address |
| req_wdata | output | 32 | Left-aligned store data |
| req_wmask | output | 32 | Bit write mask |
| req_wbe | output | 4 | Byte write enables |
| req_rmask | output | 32 | Load extension mask |
| req_shamt | output | 5 | Right-shift amount for load alignment |
| req_dest | output | 5 | Writeback register index, 0 for stores |

## Verification
Decoding sits in one combinational layer in front of a single register. A wrong size decode or extension choice therefore shows on the request outputs in the first cycle after the offending instruction, and it does not linger into later requests. A stuck or wrong store flag shows at once as a nonzero write mask on a load, or as a nonzero destination on a store. A wrong valid or hold path shows as an extra or missing request strobe, or as outputs that change during idle cycles.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
   localparam int unsigned LSF_DATA_W = 32;
   localparam int unsigned LSF_IMM_W  = 16;
   localparam int unsigned LSF_RIDX_W = 5;

   // request index field and store flag positions in the instruction word
   localparam int unsigned LSF_IDX_LO   = 26;
   localparam int unsigned LSF_STORE_BIT = 29;
   localparam int unsigned LSF_RT_LO    = 16;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_TRIPLE = 2'd2,
      SZ_WORD  = 2'd3
   } lsf_size_e;
endpackage

// File: rtl/lsf_addr_gen.sv
module lsf_addr_gen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IMM_W  = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int unsigned EXT_W = ADDR_W - IMM_W;

   generate
      if (IMM_W >= ADDR_W) begin : g_bad_imm
         $error("lsf_addr_gen: IMM_W must be narrower than ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] imm_ext;
   assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign addr_o  = base_i + imm_ext;
endmodule

// File: rtl/lsf_size_decode.sv
module lsf_size_decode
   import lsf_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]                  req_idx_i,
   input  logic                        is_store_i,
   output logic [$clog2(DATA_W)-1:0]   shamt_o,
   output logic [DATA_W-1:0]           wmask_o,
   output logic [DATA_W-1:0]           rmask_o
);
   localparam int unsigned SH_W  = $clog2(DATA_W);
   localparam int unsigned NBYTE = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("lsf_size_decode: the two-bit size code covers 32-bit data only");
      end
   endgenerate

   lsf_size_e size;
   logic      zero_ext;
   logic      no_ext;

   assign size     = lsf_size_e'(req_idx_i[1:0]);
   assign zero_ext = req_idx_i[2];
   // size code 2 has no defined extension: mask collapses to zero
   assign no_ext   = (size == SZ_TRIPLE);

   // (3 - size) * 8, the complement of a two-bit code is 3 - code
   assign shamt_o = SH_W'({~req_idx_i[1:0], 3'b000});

   logic [DATA_W-1:0] ones_shifted;
   assign ones_shifted = {DATA_W{1'b1}} << shamt_o;
   assign wmask_o      = is_store_i ? ones_shifted : '0;

   // per-byte read mask: full when sign-extending or word; partial when zero-extending
   logic [NBYTE-1:0] rbyte_en;
   for (genvar b = 0; b < NBYTE; b++) begin : g_rbyte
      always_comb begin
         if (no_ext)
            rbyte_en[b] = 1'b0;
         else if (!zero_ext || size == SZ_WORD)
            rbyte_en[b] = 1'b1;
         else
            rbyte_en[b] = (b <= int'(req_idx_i[1:0]));
      end
      assign rmask_o[8*b +: 8] = {8{rbyte_en[b]}};
   end
endmodule

// File: rtl/lsf_data_align.sv
module lsf_data_align #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]          src_i,
   input  logic [$clog2(DATA_W)-1:0]  shamt_i,
   input  logic [DATA_W-1:0]          wmask_i,
   output logic [DATA_W-1:0]          wdata_o,
   output logic [DATA_W/8-1:0]        wbe_o
);
   localparam int unsigned NBYTE = DATA_W / 8;

   assign wdata_o = src_i << shamt_i;

   for (genvar b = 0; b < NBYTE; b++) begin : g_wbe
      assign wbe_o[b] = wmask_i[8*b + 7];
   end
endmodule

// File: rtl/ldst_req_fmt.sv
module ldst_req_fmt
   import lsf_pkg::*;
#(
   parameter int unsigned DATA_W = LSF_DATA_W,
   parameter int unsigned IMM_W  = LSF_IMM_W,
   parameter int unsigned RIDX_W = LSF_RIDX_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [31:0]                instr,
   input  logic [DATA_W-1:0]          base_val,
   input  logic [DATA_W-1:0]          src_val,
   output logic                       req_valid,
   output logic [DATA_W-1:0]          req_addr,
   output logic [DATA_W-1:0]          req_wdata,
   output logic [DATA_W-1:0]          req_wmask,
   output logic [DATA_W/8-1:0]        req_wbe,
   output logic [DATA_W-1:0]          req_rmask,
   output logic [$clog2(DATA_W)-1:0]  req_shamt,
   output logic [RIDX_W-1:0]          req_dest
);
   localparam int unsigned SH_W  = $clog2(DATA_W);
   localparam int unsigned NBYTE = DATA_W / 8;

   generate
      if (RIDX_W != 5) begin : g_bad_ridx
         $error("ldst_req_fmt: register index field is five bits wide");
      end
   endgenerate

   logic              is_store;
   logic [2:0]        req_idx;
   logic [DATA_W-1:0] addr_c, wdata_c, wmask_c, rmask_c;
   logic [NBYTE-1:0]  wbe_c;
   logic [SH_W-1:0]   shamt_c;
   logic [RIDX_W-1:0] dest_c;

   assign is_store = instr[LSF_STORE_BIT];
   assign req_idx  = instr[LSF_IDX_LO +: 3];
   assign dest_c   = is_store ? '0 : instr[LSF_RT_LO +: RIDX_W];

   lsf_addr_gen #(.ADDR_W(DATA_W), .IMM_W(IMM_W)) addr_i (
      .base_i (base_val),
      .imm_i  (instr[IMM_W-1:0]),
      .addr_o (addr_c)
   );

   lsf_size_decode #(.DATA_W(DATA_W)) size_i (
      .req_idx_i  (req_idx),
      .is_store_i (is_store),
      .shamt_o    (shamt_c),
      .wmask_o    (wmask_c),
      .rmask_o    (rmask_c)
   );

   lsf_data_align #(.DATA_W(DATA_W)) align_i (
      .src_i   (src_val),
      .shamt_i (shamt_c),
      .wmask_i (wmask_c),
      .wdata_o (wdata_c),
      .wbe_o   (wbe_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_wdata <= '0;
         req_wmask <= '0;
         req_wbe   <= '0;
         req_rmask <= '0;
         req_shamt <= '0;
         req_dest  <= '0;
      end else begin
         req_valid <= in_valid;
         if (in_valid) begin
            req_addr  <= addr_c;
            req_wdata <= wdata_c;
            req_wmask <= wmask_c;
            req_wbe   <= wbe_c;
            req_rmask <= rmask_c;
            req_shamt <= shamt_c;
            req_dest  <= dest_c;
         end
      end
   end
endmodule

// File: rtl/lsf_req_fmt_chk.sv
module lsf_req_fmt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] instr,
   input logic [31:0] base_val,
   input logic [31:0] src_val,
   input logic        req_valid,
   input logic [31:0] req_addr,
   input logic [31:0] req_wdata,
   input logic [31:0] req_wmask,
   input logic [3:0]  req_wbe,
   input logic [31:0] req_rmask,
   input logic [4:0]  req_shamt,
   input logic [4:0]  req_dest
);
   assert_addr_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> req_addr == $past(base_val) + {{16{$past(instr[15])}}, $past(instr[15:0])});

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> req_valid);

   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !req_valid);

   assert_load_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[29]) |=> req_wmask == 32'h0);

   assert_wbe_tracks_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_wbe == {req_wmask[31], req_wmask[23], req_wmask[15], req_wmask[7]}));

   assert_store_dest_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[29]) |=> req_dest == 5'd0);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(req_addr) && $stable(req_wdata) && $stable(req_rmask) && $stable(req_dest)));
endmodule

bind ldst_req_fmt lsf_req_fmt_chk chk_i (.*);

// File: tb/ldst_req_fmt_tb_top.sv
module ldst_req_fmt_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] instr, base_val, src_val;
   logic        req_valid;
   logic [31:0] req_addr, req_wdata, req_wmask, req_rmask;
   logic [3:0]  req_wbe;
   logic [4:0]  req_shamt, req_dest;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   typedef struct {
      logic [31:0] addr, wdata, wmask, rmask;
      logic [3:0]  wbe;
      logic [4:0]  shamt, dest;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ldst_req_fmt dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .base_val(base_val), .src_val(src_val), .req_valid(req_valid),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
      .req_wbe(req_wbe), .req_rmask(req_rmask), .req_shamt(req_shamt),
      .req_dest(req_dest)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [31:0] iw, input logic [31:0] b, input logic [31:0] s);
      exp_t e;
      logic st;
      st = iw[29];
      e.addr = b + {{16{iw[15]}}, iw[15:0]};
      case (iw[27:26])
         2'd0: begin e.shamt = 5'd24; e.wmask = 32'hFF00_0000; e.wbe = 4'b1000; end
         2'd1: begin e.shamt = 5'd16; e.wmask = 32'hFFFF_0000; e.wbe = 4'b1100; end
         2'd2: begin e.shamt = 5'd8;  e.wmask = 32'hFFFF_FF00; e.wbe = 4'b1110; end
         default: begin e.shamt = 5'd0; e.wmask = 32'hFFFF_FFFF; e.wbe = 4'b1111; end
      endcase
      if (!st) begin e.wmask = 32'h0; e.wbe = 4'b0000; end
      e.wdata = s << e.shamt;
      case (iw[28:26])
         3'd2, 3'd6: e.rmask = 32'h0;
         3'd4:       e.rmask = 32'h0000_00FF;
         3'd5:       e.rmask = 32'h0000_FFFF;
         default:    e.rmask = 32'hFFFF_FFFF;
      endcase
      e.dest = st ? 5'd0 : iw[20:16];
      return e;
   endfunction

   // driver: called right after a falling edge
   task automatic drive(input logic [31:0] iw, input logic [31:0] b, input logic [31:0] s);
      instr = iw; base_val = b; src_val = s; in_valid = 1'b1;
      sb_q.push_back(model(iw, b, s));
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: compares at falling edges, one cycle after each accepted input
   exp_t last_seen;
   logic have_last = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (req_valid) begin
            if (sb_q.size() == 0) begin
               chk("R2 unexpected strobe", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk("R1 addr", req_addr, e.addr);
               chk("R3 shamt", {27'd0, req_shamt}, {27'd0, e.shamt});
               chk("R4 wdata", req_wdata, e.wdata);
               chk("R5 wmask", req_wmask, e.wmask);
               chk("R6 wbe", {28'd0, req_wbe}, {28'd0, e.wbe});
               chk("R7 dest", {27'd0, req_dest}, {27'd0, e.dest});
               chk("R8 rmask", req_rmask, e.rmask);
               last_seen = e; have_last = 1'b1;
            end
         end else if (have_last) begin
            chk("R9 hold addr", req_addr, last_seen.addr);
            chk("R9 hold wdata", req_wdata, last_seen.wdata);
            chk("R9 hold dest", {27'd0, req_dest}, {27'd0, last_seen.dest});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; instr = '0; base_val = '0; src_val = '0;
      repeat (3) @(negedge clk);
      // reset state
      chk("R2 reset valid", {31'd0, req_valid}, 32'd0);
      chk("R2 reset addr", req_addr, 32'd0);
      chk("R2 reset wmask", req_wmask, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // every request index, as load and as store
      for (int st = 0; st < 2; st++) begin
         for (int idx = 0; idx < 8; idx++) begin
            logic [31:0] iw;
            iw = {2'b10, st[0], idx[2:0], 5'd3, 5'(idx + 9), 16'h0010 + 16'(idx)};
            drive(iw, 32'h0000_1000 + 32'(idx * 4), 32'hA1B2_C3D4 ^ 32'(idx));
         end
      end
      // negative offset, address wrap, idle gap between requests (R9)
      drive({2'b10, 1'b0, 3'd4, 5'd1, 5'd31, 16'hFFFC}, 32'h0000_0002, 32'h1234_5678);
      @(negedge clk); @(negedge clk);
      drive({2'b10, 1'b1, 3'd1, 5'd2, 5'd7, 16'h8000}, 32'h0000_4000, 32'hDEAD_BEEF);
      drive({2'b10, 1'b1, 3'd3, 5'd2, 5'd7, 16'h7FFF}, 32'hFFFF_FFFF, 32'h8000_0001);
      @(negedge clk);
      drive({2'b11, 1'b0, 3'd5, 5'd4, 5'd20, 16'h0001}, 32'h8000_0000, 32'hFFFF_FFFF);
      drive({2'b10, 1'b1, 3'd0, 5'd4, 5'd20, 16'hFFFF}, 32'h0000_0000, 32'h0000_00AB);
      repeat (3) @(negedge clk);

      // R2: every pushed request was seen exactly once
      chk("R2 scoreboard drained", 32'(sb_q.size()), 32'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule